// File: doc/BRIEF.md
# CAN Bit Stuffing Codec

This block sits between a CAN frame sequencer and the bit-timing logic. It carries two independent one-bit streams. On the transmit path it adds stuff bits. On the receive path it takes them out again. Each stream moves one bit per handshake on a valid/ready pair. Levels are NRZ: a 1 is the recessive level and a 0 is the dominant level.

Each bit carries two sideband flags from the sequencer.
- The enable flag is high for every bit of the stuffed region. That region runs from the start-of-frame bit through the last CRC bit.
- The frame-start flag marks the start-of-frame bit. It restarts run counting.

The rules for the stuffed region are these:
- The transmit path follows any run of five equal bits with one bit of the opposite level.
- The receive path drops that bit.
- If the receive path sees a sixth equal bit where a stuff bit should be, it raises a one-cycle stuff-error pulse.

Bits outside the stuffed region pass through unchanged on both paths. This covers the CRC delimiter, the ACK slot and its delimiter, end of frame, and error or overload frames.

Top module: `can_stuff_codec`

## Requirements
- R1: On the transmit path, when five consecutive bits of equal level have been accepted with the enable flag high, the next output beat is one bit of the opposite level (0 after a run of 1s, 1 after a run of 0s).
- R2: While the transmit path emits a stuff bit, `tx_in_ready` is low for exactly that output beat, and the pending input bit is taken on the following beat.
- R3: A transmit stuff bit opens a new run with a count of one. Four further input bits of the stuff bit's level therefore cause another stuff bit.
- R4: A transmit input bit with the enable flag low passes through unchanged and clears the run count. Any number of equal bits sent this way gets no stuff bit.
- R5: On both paths, a bit with the frame-start flag high (and the enable flag high) begins a fresh run with a count of one, whatever came before it.
- R6: On the receive path, after five equal bits with the enable flag high, the next bit is consumed without being forwarded if its level is opposite. That bit also begins a new run with a count of one.
- R7: If, in that position, the receive path gets a sixth bit of the same level, the bit is not forwarded. `rx_stuff_err` is then high for exactly one cycle, in the cycle after that bit is accepted. The run count is cleared.
- R8: A receive input bit with the enable flag low is forwarded unchanged. It never raises a stuff error, and it clears the run count and any expected stuff bit.
- R9: A transmit stuff bit that is owed after the last enabled bit is still emitted before the next input bit, even when that next bit has the enable flag low.
- R10: After reset, both run counts are zero, no stuff bit is owed, `tx_out_valid` is low when no input is offered, and `rx_stuff_err` is low.
- R11: When no stuff bit is owed, the transmit path is combinational in the same cycle: `tx_out_valid` equals `tx_in_valid`, `tx_out_bit` equals `tx_in_bit`, and `tx_in_ready` equals `tx_out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_in_valid | input | 1 | Transmit input bit offered |
| tx_in_ready | output | 1 | Transmit input bit taken this cycle |
| tx_in_bit | input | 1 | Transmit input level (1 recessive, 0 dominant) |
| tx_in_en | input | 1 | Bit lies in the stuffed region |
| tx_in_sof | input | 1 | Bit is the start-of-frame bit |
| tx_out_valid | output | 1 | Transmit output bit offered |
| tx_out_ready | input | 1 | Downstream takes the transmit output bit |
| tx_out_bit | output | 1 | Transmit output level, stuff bits included |
| rx_in_valid | input | 1 | Receive input bit offered |
| rx_in_ready | output | 1 | Receive input bit taken this cycle |
| rx_in_bit | input | 1 | Receive input level as sampled from the bus |
| rx_in_en | input | 1 | Bit lies in the stuffed region |
| rx_in_sof | input | 1 | Bit is the start-of-frame bit |
| rx_out_valid | output | 1 | Destuffed bit offered |
| rx_out_ready | input | 1 | Downstream takes the destuffed bit |
| rx_out_bit | output | 1 | Destuffed output level |
| rx_stuff_err | output | 1 | One-cycle pulse on a six-bit run |

## Verification
Forwarded bits on both paths appear in the same cycle as the input handshake. A stuff bit appears on the beat after the fifth equal bit, and `rx_stuff_err` rises one clock after the offending bit is accepted. The bench drives inputs just after a rising edge and samples every handshake and the error flag at the falling edge. A stuff bit or error pulse that closes a stream is therefore still captured during the idle cycles that follow each sequence. Streams and error counts are compared against a model of the run-count rules written in the bench.

// File: rtl/can_stuff_pkg.sv
package can_stuff_pkg;

    // Number of equal levels after which a complement bit is due.
    localparam int unsigned STUFF_RUN_DEFAULT = 5;

    // Bus levels in NRZ form.
    typedef enum logic {
        LVL_DOMINANT  = 1'b0,
        LVL_RECESSIVE = 1'b1
    } bus_level_e;

    // Next run length: restart at one, or extend the current run.
    function automatic int unsigned run_advance(input int unsigned cur, input logic restart);
        return restart ? 1 : cur + 1;
    endfunction

endpackage

// File: rtl/can_stuff_tx.sv
module can_stuff_tx
    import can_stuff_pkg::*;
#(
    parameter int unsigned RUN_LEN = STUFF_RUN_DEFAULT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic in_ready,
    input  logic in_bit,
    input  logic in_en,
    input  logic in_sof,
    output logic out_valid,
    input  logic out_ready,
    output logic out_bit
);
    localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             last;
        logic             owe;
    } tx_state_t;

    tx_state_t st_d, st_q;
    logic      take_in;
    logic      restart;

    always_comb begin
        st_d     = st_q;
        in_ready = !st_q.owe && out_ready;
        out_valid = st_q.owe || in_valid;
        out_bit  = st_q.owe ? ~st_q.last : in_bit;
        take_in  = in_valid && in_ready;
        restart  = in_sof || (st_q.cnt == '0) || (in_bit != st_q.last);

        if (st_q.owe) begin
            if (out_ready) begin
                st_d.owe  = 1'b0;
                st_d.cnt  = CNT_W'(1);
                st_d.last = ~st_q.last;
            end
        end else if (take_in) begin
            if (!in_en) begin
                st_d.cnt = '0;
                st_d.owe = 1'b0;
            end else begin
                st_d.cnt  = CNT_W'(run_advance(32'(st_q.cnt), restart));
                st_d.last = in_bit;
                st_d.owe  = (st_d.cnt == CNT_W'(RUN_LEN));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, last: LVL_RECESSIVE, owe: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/can_stuff_rx.sv
module can_stuff_rx
    import can_stuff_pkg::*;
#(
    parameter int unsigned RUN_LEN = STUFF_RUN_DEFAULT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic in_ready,
    input  logic in_bit,
    input  logic in_en,
    input  logic in_sof,
    output logic out_valid,
    input  logic out_ready,
    output logic out_bit,
    output logic stuff_err
);
    localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             last;
        logic             expect_stuff;
        logic             err;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic      dropping;
    logic      take_in;
    logic      restart;

    always_comb begin
        st_d      = st_q;
        st_d.err  = 1'b0;
        dropping  = st_q.expect_stuff && in_en && !in_sof;
        in_ready  = dropping ? 1'b1 : out_ready;
        out_valid = in_valid && !dropping;
        out_bit   = in_bit;
        take_in   = in_valid && in_ready;
        restart   = (st_q.cnt == '0) || (in_bit != st_q.last);

        if (take_in) begin
            if (!in_en) begin
                st_d.cnt          = '0;
                st_d.expect_stuff = 1'b0;
            end else if (in_sof) begin
                st_d.cnt          = CNT_W'(1);
                st_d.last         = in_bit;
                st_d.expect_stuff = 1'b0;
            end else if (st_q.expect_stuff) begin
                st_d.expect_stuff = 1'b0;
                if (in_bit == st_q.last) begin
                    st_d.err = 1'b1;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt  = CNT_W'(1);
                    st_d.last = in_bit;
                end
            end else begin
                st_d.cnt          = CNT_W'(run_advance(32'(st_q.cnt), restart));
                st_d.last         = in_bit;
                st_d.expect_stuff = (st_d.cnt == CNT_W'(RUN_LEN));
            end
        end
    end

    assign stuff_err = st_q.err;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, last: LVL_RECESSIVE, expect_stuff: 1'b0, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/can_stuff_codec.sv
module can_stuff_codec
    import can_stuff_pkg::*;
#(
    parameter int unsigned RUN_LEN = STUFF_RUN_DEFAULT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_in_valid,
    output logic tx_in_ready,
    input  logic tx_in_bit,
    input  logic tx_in_en,
    input  logic tx_in_sof,
    output logic tx_out_valid,
    input  logic tx_out_ready,
    output logic tx_out_bit,
    input  logic rx_in_valid,
    output logic rx_in_ready,
    input  logic rx_in_bit,
    input  logic rx_in_en,
    input  logic rx_in_sof,
    output logic rx_out_valid,
    input  logic rx_out_ready,
    output logic rx_out_bit,
    output logic rx_stuff_err
);

    can_stuff_tx #(.RUN_LEN(RUN_LEN)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (tx_in_valid),
        .in_ready  (tx_in_ready),
        .in_bit    (tx_in_bit),
        .in_en     (tx_in_en),
        .in_sof    (tx_in_sof),
        .out_valid (tx_out_valid),
        .out_ready (tx_out_ready),
        .out_bit   (tx_out_bit)
    );

    can_stuff_rx #(.RUN_LEN(RUN_LEN)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rx_in_valid),
        .in_ready  (rx_in_ready),
        .in_bit    (rx_in_bit),
        .in_en     (rx_in_en),
        .in_sof    (rx_in_sof),
        .out_valid (rx_out_valid),
        .out_ready (rx_out_ready),
        .out_bit   (rx_out_bit),
        .stuff_err (rx_stuff_err)
    );

endmodule

// File: rtl/can_stuff_chk.sv
module can_stuff_chk #(
    parameter int unsigned RUN_LEN = 5
) (
    input logic clk,
    input logic rst_n,
    input logic tx_in_valid,
    input logic tx_in_ready,
    input logic tx_in_bit,
    input logic tx_in_en,
    input logic tx_in_sof,
    input logic tx_out_valid,
    input logic tx_out_ready,
    input logic tx_out_bit,
    input logic rx_in_valid,
    input logic rx_in_ready,
    input logic rx_in_bit,
    input logic rx_in_en,
    input logic rx_out_valid,
    input logic rx_out_ready,
    input logic rx_out_bit,
    input logic rx_stuff_err
);
    logic tx_in_fire, tx_out_fire, tx_stuff_beat;
    int   obs_run;
    logic obs_last, obs_seen;

    assign tx_in_fire    = tx_in_valid && tx_in_ready;
    assign tx_out_fire   = tx_out_valid && tx_out_ready;
    assign tx_stuff_beat = tx_out_fire && !tx_in_fire;

    // Independent run length of the transmitted stream.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            obs_run  <= 0;
            obs_last <= 1'b1;
            obs_seen <= 1'b0;
        end else if (tx_out_fire) begin
            obs_seen <= 1'b1;
            obs_last <= tx_out_bit;
            if (tx_in_fire && !tx_in_en)
                obs_run <= 0;
            else if (tx_in_fire && tx_in_sof)
                obs_run <= 1;
            else if (obs_run != 0 && tx_out_bit == obs_last)
                obs_run <= obs_run + 1;
            else
                obs_run <= 1;
        end
    end

    a_r1_tx_run_limit: assert property (@(posedge clk) disable iff (!rst_n)
        obs_run <= int'(RUN_LEN));

    a_r1_stuff_after_full_run: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stuff_beat |-> (obs_run == int'(RUN_LEN)));

    a_r2_stuff_level_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_stuff_beat && obs_seen) |-> (tx_out_bit != obs_last));

    a_r11_tx_forward: assert property (@(posedge clk) disable iff (!rst_n)
        tx_in_fire |-> (tx_out_fire && tx_out_bit == tx_in_bit));

    a_r6_rx_forward_source: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_out_valid && rx_out_ready) |-> (rx_in_valid && rx_in_ready && rx_out_bit == rx_in_bit));

    a_r7_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stuff_err |-> $past(rx_in_valid && rx_in_ready && rx_in_en && !rx_out_valid));

    a_r7_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stuff_err |=> !rx_stuff_err);

    a_r8_rx_plain_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_in_valid && !rx_in_en) |-> rx_out_valid);

endmodule

bind can_stuff_codec can_stuff_chk #(.RUN_LEN(RUN_LEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_in_valid  (tx_in_valid),
    .tx_in_ready  (tx_in_ready),
    .tx_in_bit    (tx_in_bit),
    .tx_in_en     (tx_in_en),
    .tx_in_sof    (tx_in_sof),
    .tx_out_valid (tx_out_valid),
    .tx_out_ready (tx_out_ready),
    .tx_out_bit   (tx_out_bit),
    .rx_in_valid  (rx_in_valid),
    .rx_in_ready  (rx_in_ready),
    .rx_in_bit    (rx_in_bit),
    .rx_in_en     (rx_in_en),
    .rx_out_valid (rx_out_valid),
    .rx_out_ready (rx_out_ready),
    .rx_out_bit   (rx_out_bit),
    .rx_stuff_err (rx_stuff_err)
);

// File: tb/can_stuff_codec_test.sv
module can_stuff_codec_test;
    localparam int RUN = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_in_valid = 0, tx_in_bit = 0, tx_in_en = 0, tx_in_sof = 0, tx_out_ready = 1;
    logic rx_in_valid = 0, rx_in_bit = 0, rx_in_en = 0, rx_in_sof = 0, rx_out_ready = 1;
    logic tx_in_ready, tx_out_valid, tx_out_bit;
    logic rx_in_ready, rx_out_valid, rx_out_bit, rx_stuff_err;

    int checks = 0, errors = 0;
    logic cap_tx [0:255];
    logic cap_rx [0:255];
    int ntx = 0, nrx = 0, nerr = 0, nstall = 0;
    bit done = 0;

    always #10 clk = ~clk;

    can_stuff_codec uut (
        .clk(clk), .rst_n(rst_n),
        .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_bit(tx_in_bit),
        .tx_in_en(tx_in_en), .tx_in_sof(tx_in_sof),
        .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_bit(tx_out_bit),
        .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_in_bit(rx_in_bit),
        .rx_in_en(rx_in_en), .rx_in_sof(rx_in_sof),
        .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready), .rx_out_bit(rx_out_bit),
        .rx_stuff_err(rx_stuff_err)
    );

    // Monitor at the falling edge: every handshake here completes at the next rising edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_out_valid && tx_out_ready) begin cap_tx[ntx[7:0]] = tx_out_bit; ntx++; end
            if (rx_out_valid && rx_out_ready) begin cap_rx[nrx[7:0]] = rx_out_bit; nrx++; end
            if (rx_stuff_err) nerr++;
            if (tx_in_valid && !tx_in_ready && tx_out_valid && tx_out_ready) nstall++;
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #2;
    endtask

    task automatic push_tx(input logic b, input logic en, input logic sof);
        tx_in_valid = 1; tx_in_bit = b; tx_in_en = en; tx_in_sof = sof;
        @(negedge clk);
        while (!tx_in_ready) @(negedge clk);
        @(posedge clk); #2;
        tx_in_valid = 0; tx_in_sof = 0;
    endtask

    task automatic push_rx(input logic b, input logic en, input logic sof);
        rx_in_valid = 1; rx_in_bit = b; rx_in_en = en; rx_in_sof = sof;
        @(negedge clk);
        while (!rx_in_ready) @(negedge clk);
        @(posedge clk); #2;
        rx_in_valid = 0; rx_in_sof = 0;
    endtask

    // Sends bits; enable high for index < en_upto; frame start at index sof_at.
    task automatic run_tx(input string bits, input int en_upto, input int sof_at,
                          input string req, input bit chk_stall);
        logic exp_q [0:255];
        int nexp = 0, cnt = 0, exp_stall = 0, bad = -1;
        logic last = 1;
        for (int i = 0; i < bits.len(); i++) begin
            logic b = (bits[i] == "1");
            logic en = (i < en_upto);
            if (!en) cnt = 0;
            else if (i == sof_at || cnt == 0 || b != last) begin cnt = 1; last = b; end
            else cnt++;
            exp_q[nexp] = b; nexp++;
            if (en && cnt == RUN) begin
                exp_q[nexp] = ~b; nexp++;
                last = ~b; cnt = 1;
                if (i < bits.len() - 1) exp_stall++;
            end
        end
        ntx = 0; nstall = 0;
        for (int i = 0; i < bits.len(); i++)
            push_tx(bits[i] == "1", i < en_upto, i == sof_at);
        idle(4);
        check(ntx == nexp, req, "tx stream length", ntx, nexp);
        for (int k = 0; k < nexp && k < ntx; k++)
            if (bad < 0 && cap_tx[k] !== exp_q[k]) bad = k;
        check(bad < 0, req, "tx stream first mismatch index", bad, -1);
        if (chk_stall) check(nstall == exp_stall, req, "tx input stall beats", nstall, exp_stall);
    endtask

    task automatic run_rx(input string bits, input int en_upto, input int sof_at, input string req);
        logic exp_q [0:255];
        int nexp = 0, cnt = 0, exp_err = 0, bad = -1;
        logic last = 1, drop = 0;
        for (int i = 0; i < bits.len(); i++) begin
            logic b = (bits[i] == "1");
            if (i >= en_upto) begin cnt = 0; drop = 0; exp_q[nexp] = b; nexp++; end
            else if (i == sof_at) begin cnt = 1; last = b; drop = 0; exp_q[nexp] = b; nexp++; end
            else if (drop) begin
                drop = 0;
                if (b == last) begin exp_err++; cnt = 0; end
                else begin cnt = 1; last = b; end
            end else begin
                if (cnt != 0 && b == last) cnt++; else cnt = 1;
                last = b;
                exp_q[nexp] = b; nexp++;
                drop = (cnt == RUN);
            end
        end
        nrx = 0; nerr = 0;
        for (int i = 0; i < bits.len(); i++)
            push_rx(bits[i] == "1", i < en_upto, i == sof_at);
        idle(4);
        check(nrx == nexp, req, "rx stream length", nrx, nexp);
        for (int k = 0; k < nexp && k < nrx; k++)
            if (bad < 0 && cap_rx[k] !== exp_q[k]) bad = k;
        check(bad < 0, req, "rx stream first mismatch index", bad, -1);
        check(nerr == exp_err, req, "rx stuff error pulses", nerr, exp_err);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(tx_out_valid == 0, "R10", "tx_out_valid in reset", tx_out_valid, 0);
        check(rx_stuff_err == 0, "R10", "rx_stuff_err in reset", rx_stuff_err, 0);
        rst_n = 1;
        idle(2);
        @(negedge clk);
        check(tx_out_valid == 0 && rx_stuff_err == 0, "R10", "outputs idle after reset",
              {tx_out_valid, rx_stuff_err}, 0);
        @(posedge clk); #2;
    endtask

    task automatic t_backpressure;
        tx_out_ready = 0; tx_in_valid = 1; tx_in_bit = 1; tx_in_en = 0;
        @(negedge clk);
        check(tx_in_ready == 0, "R11", "tx_in_ready under backpressure", tx_in_ready, 0);
        check(tx_out_valid == 1 && tx_out_bit == 1, "R11", "tx output mirrors input",
              {tx_out_valid, tx_out_bit}, 3);
        @(posedge clk); #2;
        tx_in_valid = 0; tx_out_ready = 1;
        idle(2);
    endtask

    task automatic t_loopback;
        string s = "";
        run_tx("0100000111111110", 16, 0, "R1", 0);
        for (int k = 0; k < ntx; k++) s = {s, cap_tx[k] ? "1" : "0"};
        run_rx(s, s.len(), 0, "R6");
        check(nrx == 16, "R6", "loopback recovers original length", nrx, 16);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        run_tx("00000111110", 11, 0, "R1", 1);     // two stuff bits, both stall input (R2)
        run_tx("0000011111", 10, 0, "R3", 0);      // stuff bit begins next run
        run_tx("0000000000", 0, -1, "R4", 0);      // disabled: no stuffing
        run_tx("0000000", 7, 3, "R5", 0);          // frame start restarts run
        run_tx("111111", 5, 0, "R9", 0);           // owed stuff emitted before plain bit
        t_loopback();
        run_rx("0000001", 7, 0, "R7");             // sixth equal bit -> error
        run_rx("11111111", 0, -1, "R8");           // disabled: forwarded, no error
        run_rx("11100000", 8, 3, "R5");            // frame start restarts receive run
        t_backpressure();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule